// File: doc/BRIEF.md
# Bulk Register Reply Parser

This block sits behind the receive FIFO of a bulk register transfer engine. It reads the 32-bit words that carry the peripheral's replies to queued bulk read and write commands. Before each reply arrives, the command side gives one expected-transaction entry. The entry holds the direction, the byte count and the 4-bit packet tag of the command that is outstanding. The parser then walks the reply word by word. It checks the packet markers and the tag, and it picks out the header and footer responses. For a read it unpacks the data bytes onto a ready/valid byte stream, drops the padding that the far end inserted, and checks the data CRC.

At the end of every packet the parser gives a one-cycle status. The status carries both responses and three flags: CRC mismatch, tag mismatch and framing fault. A write reply is two words. A read reply is a header word, the packed data words, a CRC word and a footer word. Any error on any packet raises a sticky abort. The abort cancels the whole transfer: incoming words are drained and dropped until software pulses the clear input.

Top module: `bulk_rsp_parser`

## Requirements
- R1: After reset the block holds `rd_valid`, `st_valid` and `abort` low, `exp_ready` high and `rx_ready` low.
- R2: A write reply is exactly two words. The header response is taken from bits 7..0 of the first word and the footer response from bits 7..0 of the second. The status reports both, and no data byte is produced.
- R3: In a read reply each data word gives bits 7..0 first and then bits 15..8. A final odd byte is taken from bits 7..0 only. Bits 15..8 of the header, CRC, footer and odd-tail words are never forwarded.
- R4: The data CRC is CRC-8, polynomial 0x07, initial value 0x00, processed MSB first over the data bytes only. A mismatch with bits 7..0 of the CRC word sets `st_crc_err`.
- R5: Response codes are Ack=0x01, Nak=0x02, NotReady=0x03, Good=0x04 and Bad=0x05. A packet is error-free only when the header is Ack, the footer is Ack or Good, and no flag is set.
- R6: A read whose header is not Ack forwards none of its data bytes and reports no CRC error. It is still parsed up to its footer.
- R7: Bit 31 marks start of packet and bit 30 marks end of packet. The first word must have bit 31 set and bit 30 clear. Every later word must have bit 31 clear. Bit 30 must appear on the footer word and on no other word. Any violation ends the packet at once with `st_frm_err` set.
- R8: Bits 19..16 of the first word are compared with the expected tag. A difference sets `st_id_err`.
- R9: Any error raises `abort` together with the status. While `abort` is high, every received word is accepted and dropped, and no data, status or expected entry is taken. `abort_clr` lowers it, but a new error in the same cycle wins.
- R10: A data byte is held on `rd_data` until `rd_ready`. No new word is accepted while bytes of the previous one are pending.
- R11: `st_valid` pulses for one cycle per packet, in the cycle after the packet's last word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exp_valid | input | 1 | Expected-transaction entry valid |
| exp_ready | output | 1 | Parser can take an expected entry |
| exp_is_read | input | 1 | 1 = read command, 0 = write command |
| exp_len | input | LEN_W | Data byte count of a read |
| exp_id | input | 4 | Expected packet tag |
| rx_valid | input | 1 | Receive word valid |
| rx_ready | output | 1 | Receive word accepted |
| rx_word | input | 32 | Received FIFO word |
| rd_valid | output | 1 | Read data byte valid |
| rd_ready | input | 1 | Read data byte taken |
| rd_data | output | 8 | Read data byte |
| st_valid | output | 1 | Per-packet status pulse |
| st_id | output | 4 | Tag of the reported packet |
| st_hdr | output | 8 | Header response |
| st_ftr | output | 8 | Footer response |
| st_crc_err | output | 1 | Data CRC mismatch |
| st_id_err | output | 1 | Tag mismatch |
| st_frm_err | output | 1 | Marker/layout fault |
| abort | output | 1 | Sticky transfer abort |
| abort_clr | input | 1 | Clears the abort |

## Verification
The assertions check the following on every cycle:
- a status lasts exactly one cycle;
- the abort stays raised until it is cleared, and is raised whenever a flagged status appears;
- no data byte is offered during an abort;
- a pending byte stays stable under back-pressure;
- the byte buffer is only reloaded once it is empty.

Only the bench scenarios can show that the byte order is correct, that padding is stripped, and that the CRC matches. They also show the framing, tag and response error cases, the suppression of data after a header that is not Ack, and the draining of words during an abort.

// File: rtl/brp_pkg.sv
package brp_pkg;

  localparam int WORD_W = 32;
  localparam int TAG_W  = 4;
  localparam int LANES  = 2;

  localparam int SOP_BIT = 31;
  localparam int EOP_BIT = 30;
  localparam int TAG_LSB = 16;

  localparam logic [7:0] RSP_ACK  = 8'h01;
  localparam logic [7:0] RSP_NAK  = 8'h02;
  localparam logic [7:0] RSP_NRDY = 8'h03;
  localparam logic [7:0] RSP_GOOD = 8'h04;
  localparam logic [7:0] RSP_BAD  = 8'h05;

  localparam logic [7:0] CRC_POLY = 8'h07;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_HDR,
    PS_DATA,
    PS_CRC,
    PS_FTR
  } pstate_t;

  // One byte through the CRC-8 shift register, MSB first.
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic       fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r  = {r[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    end
    return r;
  endfunction

endpackage

// File: rtl/brp_crc8.sv
module brp_crc8 #(
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  en,
  input  logic [LANES-1:0]      lane_en,
  input  logic [LANES-1:0][7:0] lane_byte,
  output logic [7:0]            crc
);
  import brp_pkg::*;

  logic [7:0] crc_q, crc_d;
  logic [LANES:0][7:0] chain;

  assign chain[0] = crc_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign chain[g+1] = lane_en[g] ? crc8_step(chain[g], lane_byte[g]) : chain[g];
  end

  always_comb begin
    crc_d = crc_q;
    if (clr)
      crc_d = 8'h00;
    else if (en)
      crc_d = chain[LANES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      crc_q <= 8'h00;
    else if (clr || en)
      crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/brp_byte_buf.sv
module brp_byte_buf #(
  parameter int LANES = 2,
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [CNT_W-1:0]      load_cnt,
  input  logic [LANES-1:0][7:0] load_bytes,
  output logic                  empty,
  output logic                  rd_valid,
  input  logic                  rd_ready,
  output logic [7:0]            rd_data
);

  logic [LANES-1:0][7:0] bytes_q, bytes_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [IDX_W-1:0]      head_q, head_d;
  logic                  pop;

  assign empty    = (cnt_q == '0);
  assign rd_valid = !empty;
  assign rd_data  = bytes_q[head_q];
  assign pop      = rd_valid && rd_ready;

  always_comb begin
    bytes_d = bytes_q;
    cnt_d   = cnt_q;
    head_d  = head_q;
    if (load) begin
      bytes_d = load_bytes;
      cnt_d   = load_cnt;
      head_d  = '0;
    end else if (pop) begin
      cnt_d  = cnt_q - 1'b1;
      head_d = head_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= '0;
      cnt_q   <= '0;
      head_q  <= '0;
    end else if (load || pop) begin
      bytes_q <= bytes_d;
      cnt_q   <= cnt_d;
      head_q  <= head_d;
    end
  end

  // R10: an offered byte is held until taken
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R10: the parser reloads only an empty buffer
  a_r10_load_empty: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> empty);

endmodule

// File: rtl/bulk_rsp_parser.sv
module bulk_rsp_parser #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exp_valid,
  output logic             exp_ready,
  input  logic             exp_is_read,
  input  logic [LEN_W-1:0] exp_len,
  input  logic [3:0]       exp_id,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [31:0]      rx_word,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             st_valid,
  output logic [3:0]       st_id,
  output logic [7:0]       st_hdr,
  output logic [7:0]       st_ftr,
  output logic             st_crc_err,
  output logic             st_id_err,
  output logic             st_frm_err,
  output logic             abort,
  input  logic             abort_clr
);
  import brp_pkg::*;

  localparam int CNT_W = $clog2(LANES + 1);

  // Word fields
  logic             w_sop, w_eop;
  logic [TAG_W-1:0] w_tag;
  logic [7:0]       w_lo, w_hi;
  logic             unused_rx_bits;

  assign w_sop          = rx_word[SOP_BIT];
  assign w_eop          = rx_word[EOP_BIT];
  assign w_tag          = rx_word[TAG_LSB +: TAG_W];
  assign w_lo           = rx_word[7:0];
  assign w_hi           = rx_word[15:8];
  assign unused_rx_bits = ^rx_word[29:20];

  // Packet state
  pstate_t          state_q, state_d;
  logic             is_rd_q, is_rd_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic [7:0]       hdr_q, hdr_d;
  logic             crcerr_q, crcerr_d;
  logic             pkt_en;

  // Status / abort
  logic             stv_q, stv_d;
  logic [TAG_W-1:0] sid_q, sid_d;
  logic [7:0]       shdr_q, shdr_d, sftr_q, sftr_d;
  logic             scrc_q, scrc_d, sider_q, sider_d, sfrm_q, sfrm_d;
  logic             abort_q, abort_d;

  // Helpers
  logic                  rx_fire, exp_fire, buf_empty;
  logic                  emit, e_frm, e_id, e_err;
  logic [7:0]            e_hdr, e_ftr;
  logic                  e_crc;
  logic                  buf_load;
  logic [CNT_W-1:0]      buf_cnt;
  logic [LANES-1:0][7:0] lane_bytes;
  logic                  crc_clr, crc_en;
  logic [LANES-1:0]      crc_lanes;
  logic [7:0]            crc_val;
  logic [1:0]            take;

  assign exp_ready = !abort_q && (state_q == PS_IDLE);
  assign rx_ready  = abort_q || ((state_q != PS_IDLE) && buf_empty);
  assign rx_fire   = rx_valid && rx_ready;
  assign exp_fire  = exp_valid && exp_ready;

  assign lane_bytes[0] = w_lo;
  assign lane_bytes[1] = w_hi;
  assign take          = (rem_q >= LEN_W'(2)) ? 2'd2 : 2'd1;

  // Next-state logic of the reply walker
  always_comb begin
    state_d   = state_q;
    is_rd_d   = is_rd_q;
    rem_d     = rem_q;
    tag_d     = tag_q;
    hdr_d     = hdr_q;
    crcerr_d  = crcerr_q;
    pkt_en    = 1'b0;
    emit      = 1'b0;
    e_frm     = 1'b0;
    e_id      = 1'b0;
    e_hdr     = hdr_q;
    e_ftr     = 8'h00;
    e_crc     = crcerr_q;
    buf_load  = 1'b0;
    buf_cnt   = '0;
    crc_clr   = 1'b0;
    crc_en    = 1'b0;
    crc_lanes = '0;

    case (state_q)
      PS_IDLE: begin
        if (exp_fire) begin
          pkt_en   = 1'b1;
          is_rd_d  = exp_is_read;
          rem_d    = exp_len;
          tag_d    = exp_id;
          hdr_d    = 8'h00;
          crcerr_d = 1'b0;
          crc_clr  = 1'b1;
          state_d  = PS_HDR;
        end
      end

      PS_HDR: begin
        if (rx_fire) begin
          pkt_en = 1'b1;
          if (!w_sop || w_eop || (w_tag != tag_q)) begin
            emit    = 1'b1;
            e_frm   = !w_sop || w_eop;
            e_id    = (w_tag != tag_q);
            e_hdr   = 8'h00;
            state_d = PS_IDLE;
          end else begin
            hdr_d = w_lo;
            if (!is_rd_q)
              state_d = PS_FTR;
            else if (rem_q == '0)
              state_d = PS_CRC;
            else
              state_d = PS_DATA;
          end
        end
      end

      PS_DATA: begin
        if (rx_fire) begin
          pkt_en = 1'b1;
          if (w_sop || w_eop) begin
            emit    = 1'b1;
            e_frm   = 1'b1;
            state_d = PS_IDLE;
          end else begin
            rem_d        = rem_q - LEN_W'(take);
            crc_en       = 1'b1;
            crc_lanes[0] = 1'b1;
            crc_lanes[1] = (take == 2'd2);
            buf_load     = (hdr_q == RSP_ACK);
            buf_cnt      = CNT_W'(take);
            if (rem_q <= LEN_W'(2))
              state_d = PS_CRC;
          end
        end
      end

      PS_CRC: begin
        if (rx_fire) begin
          pkt_en = 1'b1;
          if (w_sop || w_eop) begin
            emit    = 1'b1;
            e_frm   = 1'b1;
            state_d = PS_IDLE;
          end else begin
            crcerr_d = (hdr_q == RSP_ACK) && (w_lo != crc_val);
            state_d  = PS_FTR;
          end
        end
      end

      PS_FTR: begin
        if (rx_fire) begin
          pkt_en  = 1'b1;
          emit    = 1'b1;
          state_d = PS_IDLE;
          if (w_sop || !w_eop)
            e_frm = 1'b1;
          else
            e_ftr = w_lo;
        end
      end

      default: state_d = PS_IDLE;
    endcase
  end

  // Error summary of the packet being closed
  always_comb begin
    e_err = e_frm || e_id || e_crc || (e_hdr != RSP_ACK) ||
            !((e_ftr == RSP_ACK) || (e_ftr == RSP_GOOD));
  end

  // Next-state logic of status and abort
  always_comb begin
    stv_d   = emit;
    sid_d   = sid_q;
    shdr_d  = shdr_q;
    sftr_d  = sftr_q;
    scrc_d  = scrc_q;
    sider_d = sider_q;
    sfrm_d  = sfrm_q;
    if (emit) begin
      sid_d   = tag_q;
      shdr_d  = e_hdr;
      sftr_d  = e_ftr;
      scrc_d  = e_crc;
      sider_d = e_id;
      sfrm_d  = e_frm;
    end
    if (emit && e_err)
      abort_d = 1'b1;
    else if (abort_clr)
      abort_d = 1'b0;
    else
      abort_d = abort_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PS_IDLE;
      is_rd_q  <= 1'b0;
      rem_q    <= '0;
      tag_q    <= '0;
      hdr_q    <= '0;
      crcerr_q <= 1'b0;
    end else if (pkt_en) begin
      state_q  <= state_d;
      is_rd_q  <= is_rd_d;
      rem_q    <= rem_d;
      tag_q    <= tag_d;
      hdr_q    <= hdr_d;
      crcerr_q <= crcerr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stv_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      stv_q   <= stv_d;
      abort_q <= abort_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sid_q   <= '0;
      shdr_q  <= '0;
      sftr_q  <= '0;
      scrc_q  <= 1'b0;
      sider_q <= 1'b0;
      sfrm_q  <= 1'b0;
    end else if (emit) begin
      sid_q   <= sid_d;
      shdr_q  <= shdr_d;
      sftr_q  <= sftr_d;
      scrc_q  <= scrc_d;
      sider_q <= sider_d;
      sfrm_q  <= sfrm_d;
    end
  end

  brp_crc8 #(.LANES(LANES)) u_crc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (crc_clr),
    .en        (crc_en),
    .lane_en   (crc_lanes),
    .lane_byte (lane_bytes),
    .crc       (crc_val)
  );

  brp_byte_buf #(.LANES(LANES)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (buf_load),
    .load_cnt   (buf_cnt),
    .load_bytes (lane_bytes),
    .empty      (buf_empty),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data)
  );

  assign st_valid   = stv_q;
  assign st_id      = sid_q;
  assign st_hdr     = shdr_q;
  assign st_ftr     = sftr_q;
  assign st_crc_err = scrc_q;
  assign st_id_err  = sider_q;
  assign st_frm_err = sfrm_q;
  assign abort      = abort_q;

  // R11: status is a single-cycle pulse
  a_r11_status_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> !st_valid);

  // R9: abort holds until cleared
  a_r9_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    abort && !abort_clr |=> abort);

  // R9: a flagged status always comes with an abort
  a_r9_flag_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && (st_frm_err || st_id_err || st_crc_err) |-> abort);

  // R9: no data is offered during an abort
  a_r9_no_data_in_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !rd_valid);

endmodule

// File: tb/bulk_rsp_parser_bench.sv
module bulk_rsp_parser_bench;

  localparam int LEN_W = 9;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             exp_valid, exp_ready, exp_is_read;
  logic [LEN_W-1:0] exp_len;
  logic [3:0]       exp_id;
  logic             rx_valid, rx_ready;
  logic [31:0]      rx_word;
  logic             rd_valid, rd_ready;
  logic [7:0]       rd_data;
  logic             st_valid, st_crc_err, st_id_err, st_frm_err;
  logic [3:0]       st_id;
  logic [7:0]       st_hdr, st_ftr;
  logic             abort, abort_clr;

  always #2.5 clk = ~clk;

  bulk_rsp_parser #(.LEN_W(LEN_W)) u_bulk_rsp_parser (
    .clk(clk), .rst_n(rst_n),
    .exp_valid(exp_valid), .exp_ready(exp_ready), .exp_is_read(exp_is_read),
    .exp_len(exp_len), .exp_id(exp_id),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_word(rx_word),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .st_valid(st_valid), .st_id(st_id), .st_hdr(st_hdr), .st_ftr(st_ftr),
    .st_crc_err(st_crc_err), .st_id_err(st_id_err), .st_frm_err(st_frm_err),
    .abort(abort), .abort_clr(abort_clr)
  );

  int checks = 0;
  int failures = 0;
  int nb = 0;
  int nst = 0;
  logic [7:0] got [0:255];
  logic [7:0] pl [0:15];
  logic [7:0] l_hdr, l_ftr;
  logic [3:0] l_id;
  logic l_crc, l_ider, l_frm;
  logic stall_mode = 1'b0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] ref_crc(input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      c = c ^ pl[i];
      for (int b = 0; b < 8; b++)
        c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [31:0] mk(input bit s, input bit e, input logic [3:0] id,
                                     input logic [7:0] hi, input logic [7:0] lo);
    return {s, e, 10'b0, id, hi, lo};
  endfunction

  // Monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      got[nb[7:0]] = rd_data;
      nb++;
    end
    if (rst_n && st_valid) begin
      nst++;
      l_hdr = st_hdr; l_ftr = st_ftr; l_id = st_id;
      l_crc = st_crc_err; l_ider = st_id_err; l_frm = st_frm_err;
    end
  end

  always @(posedge clk) begin
    #1;
    rd_ready = stall_mode ? ~rd_ready : 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic push_exp(input bit rd, input int len, input logic [3:0] id);
    @(negedge clk);
    exp_valid = 1'b1; exp_is_read = rd; exp_len = LEN_W'(len); exp_id = id;
    while (!exp_ready) @(negedge clk);
    @(posedge clk);
    #1 exp_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    rx_valid = 1'b1; rx_word = w;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    #1 rx_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_abort();
    @(negedge clk); abort_clr = 1'b1;
    @(posedge clk); #1 abort_clr = 1'b0;
  endtask

  task automatic read_reply(input logic [3:0] id, input int n, input logic [7:0] hdr,
                            input logic [7:0] ftr, input logic [7:0] crc_flip);
    send_word(mk(1, 0, id, 8'hEE, hdr));
    for (int i = 0; i < n; i += 2) begin
      if (i + 1 < n) send_word(mk(0, 0, 4'h0, pl[i+1], pl[i]));
      else           send_word(mk(0, 0, 4'h0, 8'hEE, pl[i]));
    end
    send_word(mk(0, 0, 4'h0, 8'hEE, ref_crc(n) ^ crc_flip));
    send_word(mk(0, 1, 4'h0, 8'hEE, ftr));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!rd_valid && !st_valid && !abort, "R1 outputs idle", {rd_valid, st_valid, abort}, 0);
    chk(exp_ready && !rx_ready, "R1 ready pattern", {exp_ready, rx_ready}, 2);
  endtask

  task automatic t_write_ok();
    int s0 = nst, b0 = nb;
    push_exp(0, 6, 4'h3);
    send_word(mk(1, 0, 4'h3, 8'hEE, 8'h01));
    send_word(mk(0, 1, 4'h0, 8'hEE, 8'h04));
    settle();
    chk(nst == s0 + 1, "R11 one status", nst - s0, 1);
    chk(l_hdr == 8'h01 && l_ftr == 8'h04, "R2 responses", {l_hdr, l_ftr}, 16'h0104);
    chk(nb == b0 && !abort && l_id == 4'h3, "R2 no data no abort", nb - b0, 0);
  endtask

  task automatic t_read(input int n, input bit stall);
    int b0 = nb, s0 = nst;
    bit ok = 1;
    for (int i = 0; i < n; i++) pl[i] = 8'(8'h30 + i * 7);
    stall_mode = stall;
    push_exp(1, n, 4'h5);
    read_reply(4'h5, n, 8'h01, 8'h04, 8'h00);
    settle();
    stall_mode = 1'b0;
    chk(nb - b0 == n, stall ? "R10 byte count" : "R3 byte count", nb - b0, n);
    for (int i = 0; i < n; i++)
      if (got[8'(b0 + i)] != pl[i]) ok = 0;
    chk(ok, stall ? "R10 byte order under stall" : "R3 byte order", 0, 1);
    chk(nst == s0 + 1 && !l_crc && !l_frm && !l_ider && !abort, "R4 crc accepted",
        {l_crc, l_frm, l_ider, abort}, 0);
  endtask

  task automatic t_crc_err();
    int s0, b0;
    for (int i = 0; i < 4; i++) pl[i] = 8'(8'hA0 + i);
    push_exp(1, 4, 4'h6);
    read_reply(4'h6, 4, 8'h01, 8'h04, 8'h5A);
    settle();
    chk(l_crc && abort, "R4 crc mismatch aborts", {l_crc, abort}, 3);
    s0 = nst; b0 = nb;
    send_word(mk(1, 0, 4'h7, 8'h11, 8'h01));
    send_word(mk(0, 1, 4'h0, 8'h11, 8'h04));
    settle();
    chk(nst == s0 && nb == b0 && !exp_ready, "R9 drain during abort", nst - s0, 0);
    clear_abort();
    @(negedge clk);
    chk(!abort && exp_ready, "R9 clear", abort, 0);
  endtask

  task automatic t_hdr_nak();
    int b0 = nb;
    for (int i = 0; i < 3; i++) pl[i] = 8'(8'h10 + i);
    push_exp(1, 3, 4'h8);
    read_reply(4'h8, 3, 8'h02, 8'h02, 8'h33);
    settle();
    chk(nb == b0, "R6 no data after Nak", nb - b0, 0);
    chk(l_hdr == 8'h02 && !l_crc && !l_frm && abort, "R6 status after Nak",
        {l_hdr, 3'(l_crc), l_frm}, 16'h0200);
    clear_abort();
  endtask

  task automatic t_id_err();
    push_exp(0, 1, 4'h9);
    send_word(mk(1, 0, 4'hA, 8'h00, 8'h01));
    settle();
    chk(l_ider && !l_frm && abort, "R8 tag mismatch", {l_ider, l_frm, abort}, 5);
    send_word(mk(0, 1, 4'h0, 8'h00, 8'h04));
    clear_abort();
  endtask

  task automatic t_sop_mid();
    int s0;
    pl[0] = 8'h01; pl[1] = 8'h02;
    push_exp(1, 4, 4'hB);
    send_word(mk(1, 0, 4'hB, 8'h00, 8'h01));
    s0 = nst;
    send_word(mk(1, 0, 4'hB, 8'h02, 8'h01));
    settle();
    chk(nst == s0 + 1 && l_frm && abort, "R7 start marker mid-packet", {l_frm, abort}, 3);
    send_word(mk(0, 0, 4'h0, 8'h04, 8'h03));
    send_word(mk(0, 1, 4'h0, 8'h00, 8'h04));
    settle();
    chk(nst == s0 + 1, "R9 no status while aborted", nst - s0, 1);
    clear_abort();
  endtask

  task automatic t_no_eop();
    push_exp(0, 1, 4'hC);
    send_word(mk(1, 0, 4'hC, 8'h00, 8'h01));
    send_word(mk(0, 0, 4'h0, 8'h00, 8'h04));
    settle();
    chk(l_frm && abort, "R7 missing end marker", {l_frm, abort}, 3);
    clear_abort();
  endtask

  task automatic t_bad_responses();
    push_exp(0, 1, 4'hD);
    send_word(mk(1, 0, 4'hD, 8'h00, 8'h01));
    send_word(mk(0, 1, 4'h0, 8'h00, 8'h05));
    settle();
    chk(l_ftr == 8'h05 && abort && !l_frm, "R5 footer Bad aborts", {l_ftr, abort}, 16'h0501);
    clear_abort();
    push_exp(0, 1, 4'hE);
    send_word(mk(1, 0, 4'hE, 8'h00, 8'h03));
    send_word(mk(0, 1, 4'h0, 8'h00, 8'h01));
    settle();
    chk(l_hdr == 8'h03 && abort, "R5 header NotReady aborts", {l_hdr, abort}, 16'h0301);
    @(negedge clk);
    abort_clr = 1'b1;
    @(negedge clk);
    abort_clr = 1'b0;
    @(negedge clk);
    chk(!abort, "R9 clear after response error", abort, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    exp_valid = 1'b0; exp_is_read = 1'b0; exp_len = '0; exp_id = '0;
    rx_valid = 1'b0; rx_word = '0; rd_ready = 1'b1; abort_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_ok();
    t_read(4, 0);
    t_read(5, 0);
    t_read(7, 1);
    t_crc_err();
    t_hdr_nak();
    t_id_err();
    t_sop_mid();
    t_no_eop();
    t_bad_responses();
    t_read(2, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule